// File: doc/BRIEF.md
# Saturating Up/Down Counter with Load and Clear

This block is a small unsigned synchronous counter that moves one step per enabled clock edge, upward or downward as a direction input selects. At either end of its range it stops rather than wrapping around: counting up from the largest value keeps the largest value, and counting down from zero keeps zero. It offers the present count and its bitwise inverse as outputs.

Two ways exist to return the count to zero: a synchronous reset that acts on every rising edge it is high, and a local clear input that acts only on enabled edges. A parallel load input places an arbitrary value into the counter. The controls follow a fixed priority: clear first, then load, then counting in the selected direction. With the enable low, the count holds whatever the other controls do.

Top module: `sat_updown_counter`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, `q` becomes 0 after that edge, whatever the values of `en`, `clr`, `load` and `dir_up`.
- R2: When `rst` is 0, `en` is 1 and `clr` is 1 at a rising edge, `q` becomes 0 after that edge, whatever `load`, `load_val` and `dir_up` are.
- R3: When `rst` is 0, `en` is 1, `clr` is 0 and `load` is 1 at a rising edge, `q` takes the value of `load_val` after that edge, whatever `dir_up` is.
- R4: When `rst`, `clr` and `load` are 0, `en` is 1, `dir_up` is 1 and `q` is below its largest value (15 with the default `WIDTH` of 4), `q` rises by exactly 1 at the edge.
- R5: Under the conditions of R4 with `q` at its largest value, `q` keeps its largest value after the edge (no wrap to 0).
- R6: When `rst`, `clr` and `load` are 0, `en` is 1, `dir_up` is 0 and `q` is above 0, `q` falls by exactly 1 at the edge.
- R7: Under the conditions of R6 with `q` at 0, `q` stays 0 after the edge (no wrap to the largest value).
- R8: `q_n` equals the bitwise inverse of `q` at all times.
- R9: When `rst` is 0 and `en` is 0 at a rising edge, `q` keeps its value; `clr`, `load`, `load_val` and `dir_up` have no effect on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high, sets the count to 0 |
| en | input | 1 | Clock enable for clear, load and counting |
| clr | input | 1 | Local clear, highest priority among the enabled controls |
| load | input | 1 | Parallel load request, second priority |
| load_val | input | WIDTH | Value placed in the counter by a load |
| dir_up | input | 1 | Count direction: 1 counts up, 0 counts down |
| q | output | WIDTH | Present count |
| q_n | output | WIDTH | Bitwise inverse of the count |

## Verification
Directed runs drive the counter into both ends of its range and then keep pushing outward, which separates saturation from wrapping, and combine clear with load and load with direction on one edge to pin the priority order. Edges with the enable low but clear or load high tell a true hold apart from a control that leaks through the enable, and a reset asserted with the enable low shows that reset is not gated. A long stretch of seeded random control and data, weighted toward counting so the count travels across the whole range, is compared edge by edge with a reference model in the bench, and both outputs are checked after every edge.

// File: rtl/sat_updown_counter.sv
module sat_updown_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dir_up,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_MIN = '0;

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] step_val;
  logic             at_top;
  logic             at_bot;

  assign at_top = (cnt == CNT_MAX);
  assign at_bot = (cnt == CNT_MIN);

  always_comb begin
    if (dir_up) step_val = at_top ? cnt : cnt + 1'b1;
    else        step_val = at_bot ? cnt : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= CNT_MIN;
    else if (en) begin
      if (clr)       cnt <= CNT_MIN;
      else if (load) cnt <= load_val;
      else           cnt <= step_val;
    end
  end

  assign q   = cnt;
  assign q_n = ~cnt;

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> q == CNT_MIN);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    en && clr |=> q == CNT_MIN);

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    en && !clr && load |=> q == $past(load_val));

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    en && !clr && !load && dir_up && q != CNT_MAX |=> q == $past(q) + 1'b1);

  // R5
  top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    en && !clr && !load && dir_up && q == CNT_MAX |=> q == CNT_MAX);

  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    en && !clr && !load && !dir_up && q != CNT_MIN |=> q == $past(q) - 1'b1);

  // R7
  bot_sat_chk: assert property (@(posedge clk) disable iff (rst)
    en && !clr && !load && !dir_up && q == CNT_MIN |=> q == CNT_MIN);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

endmodule

// File: tb/sim_sat_updown_counter.sv
module sim_sat_updown_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic clk = 1'b0;
  logic rst, en, clr, load, dir_up;
  logic [W-1:0] load_val, q, q_n;
  logic [W-1:0] model;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_updown_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .load(load),
    .load_val(load_val), .dir_up(dir_up), .q(q), .q_n(q_n)
  );

  function automatic logic [W-1:0] next_cnt(logic [W-1:0] cur, logic r, logic e,
      logic c, logic l, logic [W-1:0] v, logic up);
    if (r) return '0;
    if (!e) return cur;
    if (c) return '0;
    if (l) return v;
    if (up) return (cur == TOP) ? cur : cur + 1'b1;
    return (cur == '0) ? cur : cur - 1'b1;
  endfunction

  function automatic string req_of(logic [W-1:0] cur, logic r, logic e,
      logic c, logic l, logic up);
    if (r) return "R1";
    if (!e) return "R9";
    if (c) return "R2";
    if (l) return "R3";
    if (up) return (cur == TOP) ? "R5" : "R4";
    return (cur == '0) ? "R7" : "R6";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic r, logic e, logic c, logic l, logic [W-1:0] v, logic up);
    string tag;
    rst = r; en = e; clr = c; load = l; load_val = v; dir_up = up;
    tag = req_of(model, r, e, c, l, up);
    @(posedge clk);
    model = next_cnt(model, r, e, c, l, v, up);
    @(negedge clk);
    check(tag, q, model);
    check("R8", q_n, ~model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    model = '0;
    rst = 1'b1; en = 1'b0; clr = 1'b0; load = 1'b0; load_val = '0; dir_up = 1'b0;
    @(negedge clk);
    // R1: reset with enable low still clears
    step(1, 0, 0, 0, 4'd0, 0);
    step(0, 1, 0, 1, 4'd14, 0);   // R3
    step(0, 1, 0, 0, 4'd0, 1);    // R4 to 15
    step(0, 1, 0, 0, 4'd0, 1);    // R5 hold at 15
    step(0, 1, 0, 0, 4'd0, 1);    // R5
    step(0, 0, 1, 1, 4'd2, 0);    // R9 clr/load ignored
    step(0, 1, 1, 1, 4'd3, 1);    // R2 clear beats load
    step(0, 1, 0, 0, 4'd0, 0);    // R7 hold at 0
    step(0, 1, 0, 1, 4'd5, 1);    // R3 load beats direction
    step(0, 1, 0, 0, 4'd0, 0);    // R6 down to 4
    step(0, 0, 0, 0, 4'd0, 1);    // R9 hold
    step(1, 1, 0, 1, 4'd9, 1);    // R1 reset beats load
    for (int i = 0; i < 400; i++) begin
      logic r, e, c, l, up;
      r  = ($urandom % 64) == 0;
      e  = ($urandom % 8) != 0;
      c  = ($urandom % 16) == 0;
      l  = ($urandom % 10) == 0;
      up = (i / 40) % 2 == 0 ? ($urandom % 5) != 0 : ($urandom % 5) == 0;
      step(r, e, c, l, W'($urandom), up);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule